// File: doc/BRIEF.md
# Parallel SCSI Target Bus Sequencer

This block sits on the target side of a narrow, 8-bit parallel SCSI bus and turns simple user commands into correctly timed bus activity. A command either enters an information-transfer phase and moves a given number of bytes, or releases the bus. Entering a phase from idle takes ownership by asserting BSY. The phase code is placed on the MSG, C/D and I/O lines, and the block waits a settle time before the first REQ. It then runs the asynchronous REQ/ACK handshake once per byte, in the direction that I/O selects.

Bytes come in on a valid/ready stream and go out on a valid/ready stream. Each command ends with a one-cycle done pulse. A reserved phase code is refused and reported with an error pulse. A parity error on received data sets a sticky flag, and that flag is cleared by the next phase command. All bus pins are active low on the wire. Inside the block, a 1 on an `*_act` output means the pad pulls the wire low. Bus inputs arrive as raw wire levels and are inverted when sampled. They are expected to be synchronous to `clk` already.

Every bus timing minimum is a nanosecond parameter: settle, deskew, data release and disconnection. Each one is converted to clock cycles from `CLK_NS` and rounded up. A bus reset seen on the RST line frees every driven line and returns the block to idle.

Top module: `scsi_tgt_seq`

## Requirements
- R1: After reset, every bus output (`bsy_act`, `req_act`, `msg_act`, `cd_act`, `io_act`, `db_act`, `dbp_act`) is 0 and `cmd_ready` is 1.
- R2: A phase command with code `cmd_phase` = {MSG, C/D, I/O} asserts `bsy_act` and shows the code as `msg_act` = bit 2, `cd_act` = bit 1 and `io_act` = bit 0 in the cycle after acceptance. The valid codes are 000 data out, 001 data in, 010 command, 011 status, 110 message out and 111 message in.
- R3: Codes 100 and 101 give a done pulse together with `err_phase`. All bus outputs keep their previous values, both from idle and while connected.
- R4: The first REQ of a phase comes no earlier than ceil(400 ns / CLK_NS) cycles after the command is accepted.
- R5: In target-to-initiator phases (I/O = 1), the byte is driven on `db_act` at least ceil(45 ns / CLK_NS) cycles before REQ rises. It stays stable while REQ is asserted.
- R6: While data is driven, `dbp_act` is 1 exactly when the byte has an even number of ones, so that data plus parity is odd.
- R7: REQ stays asserted until ACK is seen asserted and then drops. REQ is not asserted again while ACK remains asserted.
- R8: In initiator-to-target phases (I/O = 0), the target drives no data or parity. The byte read at ACK is the inverted wire value, and it is delivered on `rx_data` with `rx_valid`.
- R9: When `chk_par` is 1, a received byte with even data-plus-parity sets `err_parity`. The flag is sticky, the transfer still completes, and the next phase command clears it. When `chk_par` is 0, no flag is set.
- R10: A release command frees REQ and the data lines first. At least ceil(400 ns / CLK_NS) cycles later, MSG, C/D and I/O return to 000. At least ceil(200 ns / CLK_NS) cycles after that, BSY drops and done pulses.
- R11: A low level on `scsi_rst_n` frees all bus outputs in the next cycle and returns the block to idle, with no further REQ.
- R12: `done` pulses once after the ACK of the last byte is released. A length of 0 ends with done after the settle time and produces no REQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command (idle or connected) |
| cmd_release | input | 1 | 1 = release the bus, 0 = enter phase |
| cmd_phase | input | 3 | Phase code {MSG, C/D, I/O} |
| cmd_len | input | LEN_W | Byte count for the phase |
| chk_par | input | 1 | Check parity on received bytes |
| tx_valid | input | 1 | Outgoing byte offered |
| tx_ready | output | 1 | Block takes the outgoing byte |
| tx_data | input | 8 | Outgoing byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | User takes the received byte |
| rx_data | output | 8 | Received byte |
| done | output | 1 | One-cycle end-of-command pulse |
| err_phase | output | 1 | Reserved code refused (with done) |
| err_parity | output | 1 | Sticky receive parity error |
| scsi_ack_n | input | 1 | ACK wire level |
| scsi_rst_n | input | 1 | RST wire level |
| scsi_db_n | input | 8 | Data wire levels |
| scsi_dbp_n | input | 1 | Parity wire level |
| bsy_act | output | 1 | Pull BSY low |
| req_act | output | 1 | Pull REQ low |
| msg_act | output | 1 | Pull MSG low |
| cd_act | output | 1 | Pull C/D low |
| io_act | output | 1 | Pull I/O low |
| db_act | output | 8 | Pull data bits low |
| dbp_act | output | 1 | Pull parity low |

## Verification
A wrong sequencer state shows up at the bus pins within one handshake step. Examples are a REQ that rises early after a phase change, a REQ that rises again while ACK is still held, or data lines driven in an initiator-to-target phase. A bad timer load appears as a shortened gap between phase lines, data and REQ, and also between the three steps of a release. The bench measures those gaps against cycle counts it derives itself from CLK_NS. Parity faults show up on `dbp_act` for the very byte being sent, or on `err_parity` at the done pulse of the receive phase.

// File: rtl/scsi_tgt_pkg.sv
package scsi_tgt_pkg;

    localparam int DB_W = 8;
    localparam int PH_W = 3;

    localparam logic [PH_W-1:0] PH_DATA_OUT = 3'b000;
    localparam logic [PH_W-1:0] PH_DATA_IN  = 3'b001;
    localparam logic [PH_W-1:0] PH_COMMAND  = 3'b010;
    localparam logic [PH_W-1:0] PH_STATUS   = 3'b011;
    localparam logic [PH_W-1:0] PH_MSG_OUT  = 3'b110;
    localparam logic [PH_W-1:0] PH_MSG_IN   = 3'b111;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CONN,
        S_SETTLE,
        S_TX_FETCH,
        S_TX_DESKEW,
        S_TX_REQ,
        S_TX_ACKOFF,
        S_RX_REQ,
        S_RX_ACKOFF,
        S_RX_PUSH,
        S_REL_DATA,
        S_REL_PHASE
    } seq_state_e;

    // Control lines owned by the target, 1 = wire pulled low
    typedef struct packed {
        logic            bsy;
        logic            req;
        logic [PH_W-1:0] ph;
        logic            drive;
    } ctl_t;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Reserved codes: MSG set with C/D clear
    function automatic logic ph_reserved(input logic [PH_W-1:0] ph);
        return ph[2] & ~ph[1];
    endfunction

    // Parity line asserted when the byte holds an even count of ones
    function automatic logic par_assert(input logic [DB_W-1:0] d);
        return ~^d;
    endfunction

    // Received data plus parity must hold an odd count of ones
    function automatic logic par_good(input logic [DB_W-1:0] d, input logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/scsi_tgt_timer.sv
module scsi_tgt_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired = (cnt_q == '0);

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (start && load_val != '0) |=> !expired); // R4

endmodule

// File: rtl/scsi_tgt_datapath.sv
module scsi_tgt_datapath
    import scsi_tgt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load_tx,
    input  logic [DB_W-1:0] tx_byte,
    input  logic            drive_en,
    input  logic            sample_rx,
    input  logic            chk_en,
    input  logic            clr_err,
    input  logic [DB_W-1:0] bus_db_n,
    input  logic            bus_dbp_n,
    output logic [DB_W-1:0] db_act,
    output logic            dbp_act,
    output logic [DB_W-1:0] rx_byte,
    output logic            par_err
);

    logic [DB_W-1:0] tx_q;
    logic [DB_W-1:0] rx_q;
    logic            err_q;
    logic [DB_W-1:0] bus_db;
    logic            bus_dbp;

    assign bus_db  = ~bus_db_n;
    assign bus_dbp = ~bus_dbp_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if (load_tx) begin
                tx_q <= tx_byte;
            end
            if (sample_rx) begin
                rx_q <= bus_db;
            end
            if (clr_err) begin
                err_q <= 1'b0;
            end else if (sample_rx && chk_en && !par_good(bus_db, bus_dbp)) begin
                err_q <= 1'b1;
            end
        end
    end

    assign db_act  = drive_en ? tx_q : '0;
    assign dbp_act = drive_en & par_assert(tx_q);
    assign rx_byte = rx_q;
    assign par_err = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr_err) |=> err_q); // R9

    AST_PAR_ODD_OUT: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> ($countones({db_act, dbp_act}) % 2 == 1)); // R6

endmodule

// File: rtl/scsi_tgt_seq.sv
module scsi_tgt_seq
    import scsi_tgt_pkg::*;
#(
    parameter int CLK_NS     = 8,
    parameter int SETTLE_NS  = 400,
    parameter int DESKEW_NS  = 45,
    parameter int RELEASE_NS = 400,
    parameter int DISC_NS    = 200,
    parameter int LEN_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_release,
    input  logic [2:0]       cmd_phase,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             chk_par,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [7:0]       tx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic [7:0]       rx_data,
    output logic             done,
    output logic             err_phase,
    output logic             err_parity,
    input  logic             scsi_ack_n,
    input  logic             scsi_rst_n,
    input  logic [7:0]       scsi_db_n,
    input  logic             scsi_dbp_n,
    output logic             bsy_act,
    output logic             req_act,
    output logic             msg_act,
    output logic             cd_act,
    output logic             io_act,
    output logic [7:0]       db_act,
    output logic             dbp_act
);

    localparam int SETTLE_CYC  = ns_to_cyc(SETTLE_NS, CLK_NS);
    localparam int DESKEW_CYC  = ns_to_cyc(DESKEW_NS, CLK_NS);
    localparam int RELEASE_CYC = ns_to_cyc(RELEASE_NS, CLK_NS);
    localparam int DISC_CYC    = ns_to_cyc(DISC_NS, CLK_NS);
    localparam int MAX_CYC     = max4(SETTLE_CYC, DESKEW_CYC, RELEASE_CYC, DISC_CYC);
    localparam int CW          = $clog2(MAX_CYC + 1);

    seq_state_e       st_q;
    ctl_t             ctl_q;
    logic [LEN_W-1:0] len_q;
    logic             done_q;
    logic             errph_q;

    logic             bus_rst;
    logic             ack;
    logic             any_rst;
    logic             accept;
    logic             acc_phase;
    logic             acc_rel;
    logic             last_byte;
    logic             tmr_start;
    logic [CW-1:0]    tmr_val;
    logic             tmr_done;
    logic             load_tx;
    logic             sample_rx;

    assign bus_rst   = ~scsi_rst_n;
    assign ack       = ~scsi_ack_n;
    assign any_rst   = rst | bus_rst;

    assign cmd_ready = (st_q == S_IDLE) || (st_q == S_CONN);
    assign accept    = cmd_ready && cmd_valid;
    assign acc_phase = accept && !cmd_release && !ph_reserved(cmd_phase);
    assign acc_rel   = accept && cmd_release && (st_q == S_CONN);
    assign last_byte = (len_q == LEN_W'(1));
    assign tx_ready  = (st_q == S_TX_FETCH);
    assign rx_valid  = (st_q == S_RX_PUSH);
    assign load_tx   = tx_ready && tx_valid;
    assign sample_rx = (st_q == S_RX_REQ) && ack;

    // Timer loads for each timed window
    always_comb begin
        tmr_start = 1'b0;
        tmr_val   = '0;
        if (acc_phase) begin
            tmr_start = 1'b1;
            tmr_val   = CW'(SETTLE_CYC);
        end else if (acc_rel) begin
            tmr_start = 1'b1;
            tmr_val   = CW'(RELEASE_CYC);
        end else if (load_tx) begin
            tmr_start = 1'b1;
            tmr_val   = CW'(DESKEW_CYC);
        end else if (st_q == S_REL_DATA && tmr_done) begin
            tmr_start = 1'b1;
            tmr_val   = CW'(DISC_CYC);
        end
    end

    scsi_tgt_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (any_rst),
        .start    (tmr_start),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    scsi_tgt_datapath u_dp (
        .clk       (clk),
        .rst       (any_rst),
        .load_tx   (load_tx),
        .tx_byte   (tx_data),
        .drive_en  (ctl_q.drive),
        .sample_rx (sample_rx),
        .chk_en    (chk_par),
        .clr_err   (acc_phase),
        .bus_db_n  (scsi_db_n),
        .bus_dbp_n (scsi_dbp_n),
        .db_act    (db_act),
        .dbp_act   (dbp_act),
        .rx_byte   (rx_data),
        .par_err   (err_parity)
    );

    always_ff @(posedge clk) begin
        if (any_rst) begin
            st_q    <= S_IDLE;
            ctl_q   <= '0;
            len_q   <= '0;
            done_q  <= 1'b0;
            errph_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            errph_q <= 1'b0;
            unique case (st_q)
                S_IDLE, S_CONN: begin
                    if (accept) begin
                        if (cmd_release) begin
                            if (st_q == S_IDLE) begin
                                done_q <= 1'b1;
                            end else begin
                                ctl_q.req   <= 1'b0;
                                ctl_q.drive <= 1'b0;
                                st_q        <= S_REL_DATA;
                            end
                        end else if (ph_reserved(cmd_phase)) begin
                            done_q  <= 1'b1;
                            errph_q <= 1'b1;
                        end else begin
                            ctl_q.bsy   <= 1'b1;
                            ctl_q.ph    <= cmd_phase;
                            ctl_q.drive <= 1'b0;
                            len_q       <= cmd_len;
                            st_q        <= S_SETTLE;
                        end
                    end
                end
                S_SETTLE: begin
                    if (tmr_done) begin
                        if (len_q == '0) begin
                            done_q <= 1'b1;
                            st_q   <= S_CONN;
                        end else if (ctl_q.ph[0]) begin
                            st_q <= S_TX_FETCH;
                        end else begin
                            ctl_q.req <= 1'b1;
                            st_q      <= S_RX_REQ;
                        end
                    end
                end
                S_TX_FETCH: begin
                    if (tx_valid) begin
                        ctl_q.drive <= 1'b1;
                        st_q        <= S_TX_DESKEW;
                    end
                end
                S_TX_DESKEW: begin
                    if (tmr_done) begin
                        ctl_q.req <= 1'b1;
                        st_q      <= S_TX_REQ;
                    end
                end
                S_TX_REQ: begin
                    if (ack) begin
                        ctl_q.req <= 1'b0;
                        st_q      <= S_TX_ACKOFF;
                    end
                end
                S_TX_ACKOFF: begin
                    if (!ack) begin
                        len_q <= len_q - LEN_W'(1);
                        if (last_byte) begin
                            done_q <= 1'b1;
                            st_q   <= S_CONN;
                        end else begin
                            st_q <= S_TX_FETCH;
                        end
                    end
                end
                S_RX_REQ: begin
                    if (ack) begin
                        ctl_q.req <= 1'b0;
                        st_q      <= S_RX_ACKOFF;
                    end
                end
                S_RX_ACKOFF: begin
                    if (!ack) begin
                        st_q <= S_RX_PUSH;
                    end
                end
                S_RX_PUSH: begin
                    if (rx_ready) begin
                        len_q <= len_q - LEN_W'(1);
                        if (last_byte) begin
                            done_q <= 1'b1;
                            st_q   <= S_CONN;
                        end else begin
                            ctl_q.req <= 1'b1;
                            st_q      <= S_RX_REQ;
                        end
                    end
                end
                S_REL_DATA: begin
                    if (tmr_done) begin
                        ctl_q.ph <= PH_DATA_OUT;
                        st_q     <= S_REL_PHASE;
                    end
                end
                S_REL_PHASE: begin
                    if (tmr_done) begin
                        ctl_q.bsy <= 1'b0;
                        done_q    <= 1'b1;
                        st_q      <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign bsy_act   = ctl_q.bsy;
    assign req_act   = ctl_q.req;
    assign msg_act   = ctl_q.ph[2];
    assign cd_act    = ctl_q.ph[1];
    assign io_act    = ctl_q.ph[0];
    assign done      = done_q;
    assign err_phase = errph_q;

    AST_REQ_NEEDS_BSY: assert property (@(posedge clk) disable iff (rst)
        req_act |-> bsy_act); // R2

    AST_NO_RESERVED_PHASE: assert property (@(posedge clk) disable iff (rst)
        bsy_act |-> !(msg_act && !cd_act)); // R3

    AST_DATA_STABLE_REQ: assert property (@(posedge clk) disable iff (rst)
        (req_act && $past(req_act)) |-> $stable(db_act)); // R5

    AST_REQ_DROP_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(req_act) |-> ($past(ack) || $past(bus_rst))); // R7

    AST_DRIVE_ONLY_IN: assert property (@(posedge clk) disable iff (rst)
        ((|db_act) || dbp_act) |-> io_act); // R8

    AST_BSY_LAST: assert property (@(posedge clk) disable iff (rst)
        ($fell(bsy_act) && !$past(bus_rst)) |-> ($past(ctl_q.ph) == PH_DATA_OUT && !$past(req_act))); // R10

    AST_BUS_RST_FREE: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (!bsy_act && !req_act && !dbp_act)); // R11

endmodule

// File: tb/scsi_tgt_seq_tb.sv
module scsi_tgt_seq_tb;

    localparam int CLK_NS  = 8;
    localparam int T_SET   = (400 + CLK_NS - 1) / CLK_NS;
    localparam int T_DSK   = (45 + CLK_NS - 1) / CLK_NS;
    localparam int T_REL   = (400 + CLK_NS - 1) / CLK_NS;
    localparam int T_DISC  = (200 + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_ready, cmd_release = 1'b0;
    logic [2:0] cmd_phase = 3'b000;
    logic [7:0] cmd_len = 8'd0;
    logic chk_par = 1'b0;
    logic tx_valid = 1'b0, tx_ready;
    logic [7:0] tx_data = 8'h00;
    logic rx_valid, rx_ready = 1'b1;
    logic [7:0] rx_data;
    logic done, err_phase, err_parity;
    logic scsi_ack_n = 1'b1, scsi_rst_n = 1'b1, scsi_dbp_n = 1'b1;
    logic [7:0] scsi_db_n = 8'hFF;
    logic bsy_act, req_act, msg_act, cd_act, io_act, dbp_act;
    logic [7:0] db_act;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_cnt = 0;
    int errph_cnt = 0;
    int db_chg_cyc = 0;
    int acc_cyc = 0;
    logic [8:0] db_prev = '0;

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (done) done_cnt++;
        if (done && err_phase) errph_cnt++;
        if ({db_act, dbp_act} !== db_prev) begin
            db_chg_cyc = cyc;
            db_prev = {db_act, dbp_act};
        end
    end

    scsi_tgt_seq u_dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_release(cmd_release),
        .cmd_phase(cmd_phase), .cmd_len(cmd_len), .chk_par(chk_par),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .done(done), .err_phase(err_phase), .err_parity(err_parity),
        .scsi_ack_n(scsi_ack_n), .scsi_rst_n(scsi_rst_n),
        .scsi_db_n(scsi_db_n), .scsi_dbp_n(scsi_dbp_n),
        .bsy_act(bsy_act), .req_act(req_act), .msg_act(msg_act),
        .cd_act(cd_act), .io_act(io_act), .db_act(db_act), .dbp_act(dbp_act)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic even_ones(input logic [7:0] b);
        return ($countones(b) % 2) == 0;
    endfunction

    task automatic issue(input logic rel, input logic [2:0] ph, input int len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_release = rel; cmd_phase = ph; cmd_len = len[7:0];
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        acc_cyc = cyc;
        cmd_valid = 1'b0;
    endtask

    task automatic tx_byte(input logic [7:0] b, input bit first);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1; tx_data = b;
        @(negedge clk);
        tx_valid = 1'b0;
        while (!req_act) @(negedge clk);
        if (first) chk(cyc - acc_cyc >= T_SET, "R4 settle before first REQ", cyc - acc_cyc, T_SET);
        chk(db_act == b, "R5 data on bus at REQ", db_act, b);
        chk(cyc - db_chg_cyc >= T_DSK, "R5 deskew", cyc - db_chg_cyc, T_DSK);
        chk(dbp_act == even_ones(b), "R6 parity line", dbp_act, even_ones(b));
        repeat (2) @(negedge clk);
        chk(req_act, "R7 REQ held until ACK", req_act, 1);
        scsi_ack_n = 1'b0;
        @(negedge clk);
        chk(!req_act, "R7 REQ drops after ACK", req_act, 0);
        repeat (3) @(negedge clk);
        chk(!req_act, "R7 no REQ while ACK held", req_act, 0);
        scsi_ack_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rx_byte(input logic [7:0] b, input bit good, input bit first);
        logic p;
        while (!req_act) @(negedge clk);
        if (first) chk(cyc - acc_cyc >= T_SET, "R4 settle before first REQ", cyc - acc_cyc, T_SET);
        chk(db_act == 8'h00 && !dbp_act, "R8 target not driving data", {db_act, dbp_act}, 0);
        p = good ? even_ones(b) : !even_ones(b);
        scsi_db_n = ~b; scsi_dbp_n = ~p;
        @(negedge clk);
        scsi_ack_n = 1'b0;
        @(negedge clk);
        chk(!req_act, "R7 REQ drops after ACK", req_act, 0);
        scsi_ack_n = 1'b1; scsi_db_n = 8'hFF; scsi_dbp_n = 1'b1;
        while (!rx_valid) @(negedge clk);
        chk(rx_data == b, "R8 received byte", rx_data, b);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk({bsy_act, req_act, msg_act, cd_act, io_act, db_act, dbp_act} == '0,
            "R1 bus outputs free after reset", {bsy_act, req_act, msg_act, cd_act, io_act, db_act, dbp_act}, 0);
        chk(cmd_ready, "R1 cmd_ready after reset", cmd_ready, 1);
    endtask

    task automatic t_reserved_idle;
        int d0, e0;
        d0 = done_cnt; e0 = errph_cnt;
        issue(1'b0, 3'b100, 2);
        repeat (2) @(negedge clk);
        chk(errph_cnt == e0 + 1 && done_cnt == d0 + 1, "R3 code 100 refused", errph_cnt - e0, 1);
        chk(!bsy_act && !msg_act && !req_act, "R3 bus untouched", {bsy_act, msg_act, req_act}, 0);
    endtask

    task automatic t_tx_data_in;
        int d0;
        d0 = done_cnt;
        issue(1'b0, 3'b001, 3);
        chk(bsy_act && {msg_act, cd_act, io_act} == 3'b001, "R2 BSY and DATA IN code",
            {bsy_act, msg_act, cd_act, io_act}, 4'b1001);
        tx_byte(8'hA5, 1'b1);
        tx_byte(8'h01, 1'b0);
        tx_byte(8'h00, 1'b0);
        repeat (2) @(negedge clk);
        chk(done_cnt == d0 + 1, "R12 done after last byte", done_cnt - d0, 1);
    endtask

    task automatic t_reserved_conn;
        int e0;
        e0 = errph_cnt;
        issue(1'b0, 3'b101, 1);
        repeat (2) @(negedge clk);
        chk(errph_cnt == e0 + 1, "R3 code 101 refused while connected", errph_cnt - e0, 1);
        chk(bsy_act && {msg_act, cd_act, io_act} == 3'b001, "R3 phase kept", {msg_act, cd_act, io_act}, 3'b001);
    endtask

    task automatic t_len_zero(input logic [2:0] ph);
        int d0;
        bit saw_req;
        d0 = done_cnt; saw_req = 0;
        issue(1'b0, ph, 0);
        chk({msg_act, cd_act, io_act} == ph, "R2 phase code shown", {msg_act, cd_act, io_act}, ph);
        repeat (T_SET + 6) begin
            @(negedge clk);
            if (req_act) saw_req = 1;
        end
        chk(!saw_req && done_cnt == d0 + 1, "R12 zero length ends without REQ", {saw_req, 8'(done_cnt - d0)}, 1);
    endtask

    task automatic t_rx_msg_out;
        int d0;
        d0 = done_cnt;
        chk_par = 1'b1;
        issue(1'b0, 3'b110, 2);
        chk({msg_act, cd_act, io_act} == 3'b110, "R2 MESSAGE OUT code", {msg_act, cd_act, io_act}, 3'b110);
        rx_byte(8'h3C, 1'b1, 1'b1);
        rx_byte(8'h81, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        chk(done_cnt == d0 + 1 && !err_parity, "R9 good parity no error", {done_cnt - d0, err_parity}, 2);
    endtask

    task automatic t_rx_bad_parity;
        int d0;
        d0 = done_cnt;
        chk_par = 1'b1;
        issue(1'b0, 3'b000, 2);
        rx_byte(8'h5A, 1'b0, 1'b1);
        rx_byte(8'h07, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        chk(done_cnt == d0 + 1, "R9 transfer completes despite error", done_cnt - d0, 1);
        chk(err_parity, "R9 sticky parity error", err_parity, 1);
        issue(1'b0, 3'b010, 0);
        chk(!err_parity, "R9 cleared by next phase command", err_parity, 0);
        repeat (T_SET + 4) @(negedge clk);
        chk_par = 1'b0;
        issue(1'b0, 3'b000, 1);
        rx_byte(8'hF0, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk(!err_parity, "R9 no error with checking off", err_parity, 0);
    endtask

    task automatic t_release;
        int d0, tp, tb;
        issue(1'b0, 3'b111, 1);
        tx_byte(8'h7E, 1'b1);
        repeat (2) @(negedge clk);
        d0 = done_cnt;
        issue(1'b1, 3'b000, 0);
        chk(!req_act && db_act == 0 && !dbp_act && bsy_act && {msg_act, cd_act, io_act} == 3'b111,
            "R10 data and REQ freed first", {req_act, db_act, dbp_act, bsy_act}, 1);
        while ({msg_act, cd_act, io_act} != 3'b000) @(negedge clk);
        tp = cyc;
        chk(tp - acc_cyc >= T_REL && bsy_act, "R10 release delay before phase lines", tp - acc_cyc, T_REL);
        while (bsy_act) @(negedge clk);
        tb = cyc;
        chk(tb - tp >= T_DISC, "R10 disconnection delay before BSY", tb - tp, T_DISC);
        repeat (2) @(negedge clk);
        chk(done_cnt == d0 + 1 && cmd_ready, "R10 done and idle after release", done_cnt - d0, 1);
    endtask

    task automatic t_bus_reset;
        bit saw_req;
        saw_req = 0;
        issue(1'b0, 3'b001, 2);
        repeat (5) @(negedge clk);
        scsi_rst_n = 1'b0;
        @(negedge clk);
        scsi_rst_n = 1'b1;
        chk({bsy_act, req_act, msg_act, cd_act, io_act, db_act, dbp_act} == '0 && cmd_ready,
            "R11 bus freed on RST", {bsy_act, req_act, msg_act, cd_act, io_act, db_act, dbp_act}, 0);
        repeat (T_SET + 10) begin
            @(negedge clk);
            if (req_act || bsy_act) saw_req = 1;
        end
        chk(!saw_req, "R11 stays idle after RST", saw_req, 0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reserved_idle();
        t_tx_data_in();
        t_reserved_conn();
        t_len_zero(3'b011);
        t_rx_msg_out();
        t_rx_bad_parity();
        t_release();
        t_bus_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule